// File: doc/BRIEF.md
# Eight-Channel Phase-Aligned PWM Bank

The block drives eight pulse-width-modulated outputs whose duty cycle and period are set by software through a Wishbone slave port. One free-running 31-bit counter is shared by every channel. Each channel takes an 8-bit window of that counter as its phase, so a channel that runs slower simply looks at higher counter bits. All channels therefore remain locked to one another, whatever their individual periods.

A channel has two settings. The first is a duty threshold `v`, where a larger value gives a shorter high time and zero turns the output off. The second is a divider exponent `n`, which stretches the step time to 2^n clock cycles. Software writes these settings through 32-bit word registers and can read them back.

Top module: `pwm_bank`

## Requirements
- R1: Synchronous reset `rst_i` clears every threshold, every divider exponent and the shared counter to zero. During and right after reset, all `pwm_o` bits are low and every register reads back as 0.
- R2: Addresses are byte addresses. The slave claims an access when `wb_adr_i[31:6]` equals the upper bits of 0xFEED0000, and it selects a register with the word offset `wb_adr_i[5:2]`. Offsets 0..7 hold the thresholds of channels 0..7 and offsets 8..15 hold the divider exponents of channels 0..7. When `wb_cyc_i` and `wb_stb_i` are high with an address inside the window, `wb_ack_o` rises for exactly one cycle on the next clock. An address outside the window is never acknowledged and changes no register.
- R3: A write is performed only when `wb_sel_i[0]` is 1. A threshold takes `wb_dat_i[7:0]`. A write with `wb_sel_i[0]` at 0 leaves the register unchanged.
- R4: A read returns the stored value in the low bits of `wb_dat_o`, with all other bits zero, in the cycle where `wb_ack_o` is high.
- R5: A divider write keeps `wb_dat_i[4:0]`. A kept value of 24 or more is stored as 23, so the stored exponent is always between 0 and 23.
- R6: For a threshold v in 1..255 and an exponent n, the output is high for exactly 2^n·(256−v) of every 256·2^n clock cycles.
- R7: A threshold of 0 keeps that channel's output low at all times.
- R8: The shared counter advances by one every cycle. Channel i is high in the cycle after counter bits [n_i+7:n_i] are greater than or equal to v_i. As a result, every channel with threshold 1 falls in the same cycle that all slower channels with threshold 1 fall.
- R9: A new threshold or exponent is used from the clock edge that raises `wb_ack_o`. The output reflects it one cycle later, with no waiting for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte lane selects, only lane 0 used |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| pwm_o | output | 8 | PWM outputs, bit i is channel i |

## Verification
A corrupted threshold or exponent shows up at the ports in two places. The readback shows it on the next read. The high-cycle count of the affected channel also goes wrong within one period of 256·2^n cycles. A counter that skips a step or is sliced at the wrong bit breaks the coincident falling edges of channels with different exponents within a couple of thousand cycles. An error in decode or byte-lane handling appears at once, either as a missing or spurious acknowledge or as a changed value on the next readback.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int unsigned PWM_CHANNELS  = 8;
    localparam int unsigned PWM_DUTY_BITS = 8;
    localparam int unsigned PWM_EXP_BITS  = 5;
    localparam int unsigned PWM_EXP_LIMIT = 23;
    localparam logic [31:0] PWM_BASE      = 32'hFEED_0000;

    // Upper half of the register window selects the bank.
    typedef enum logic {
        BANK_DUTY = 1'b0,
        BANK_EXP  = 1'b1
    } bank_e;
endpackage

// File: rtl/pwm_bank_cnt.sv
module pwm_bank_cnt #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
    parameter int unsigned CNT_W  = 31,
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned EXP_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DUTY_W-1:0] thr_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic              pwm_o
);
    typedef struct packed {
        logic out;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [CNT_W-1:0]  shifted;
    logic [DUTY_W-1:0] phase;
    logic              unused_hi;

    assign shifted   = cnt_i >> exp_i;
    assign phase     = shifted[DUTY_W-1:0];
    assign unused_hi = ^shifted[CNT_W-1:DUTY_W];

    always_comb begin
        st_d     = st_q;
        st_d.out = (thr_i != '0) && (phase >= thr_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pwm_o = st_q.out;
endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH     = 8,
    parameter int unsigned DUTY_W  = 8,
    parameter int unsigned EXP_W   = 5,
    parameter int unsigned EXP_MAX = 23,
    parameter logic [31:0] BASE    = 32'hFEED_0000
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         cyc_i,
    input  logic                         stb_i,
    input  logic                         we_i,
    input  logic [31:0]                  adr_i,
    input  logic [31:0]                  dat_i,
    input  logic [3:0]                   sel_i,
    output logic [31:0]                  dat_o,
    output logic                         ack_o,
    output logic [NCH-1:0][DUTY_W-1:0]   thr_o,
    output logic [NCH-1:0][EXP_W-1:0]    exp_o
);
    localparam int unsigned IDX_W   = $clog2(NCH);
    localparam int unsigned OFS_W   = IDX_W + 1;
    localparam int unsigned WIN_LSB = OFS_W + 2;

    typedef struct packed {
        logic [NCH-1:0][DUTY_W-1:0] thr;
        logic [NCH-1:0][EXP_W-1:0]  expo;
        logic                       ack;
        logic [31:0]                rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic             hit;
    logic             req;
    logic [OFS_W-1:0] word;
    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic [EXP_W-1:0] exp_raw;
    logic [EXP_W-1:0] exp_lim;
    logic             unused_bits;

    assign hit     = (adr_i[31:WIN_LSB] == BASE[31:WIN_LSB]);
    assign req     = cyc_i && stb_i && hit && !st_q.ack;
    assign word    = adr_i[WIN_LSB-1:2];
    assign bank    = bank_e'(word[OFS_W-1]);
    assign idx     = word[IDX_W-1:0];
    assign exp_raw = dat_i[EXP_W-1:0];
    assign exp_lim = (32'(exp_raw) > EXP_MAX) ? EXP_W'(EXP_MAX) : exp_raw;

    assign unused_bits = ^{adr_i[1:0], sel_i[3:1], dat_i[31:DUTY_W]};

    always_comb begin
        st_d       = st_q;
        st_d.ack   = req;
        st_d.rdata = '0;
        if (req) begin
            if (bank == BANK_DUTY) st_d.rdata[DUTY_W-1:0] = st_q.thr[idx];
            else                   st_d.rdata[EXP_W-1:0]  = st_q.expo[idx];
            if (we_i && sel_i[0]) begin
                if (bank == BANK_DUTY) st_d.thr[idx]  = dat_i[DUTY_W-1:0];
                else                   st_d.expo[idx] = exp_lim;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign dat_o = st_q.rdata;
    assign ack_o = st_q.ack;
    assign thr_o = st_q.thr;
    assign exp_o = st_q.expo;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH     = PWM_CHANNELS,
    parameter int unsigned DUTY_W  = PWM_DUTY_BITS,
    parameter int unsigned EXP_W   = PWM_EXP_BITS,
    parameter int unsigned EXP_MAX = PWM_EXP_LIMIT,
    parameter logic [31:0] BASE    = PWM_BASE
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           wb_cyc_i,
    input  logic           wb_stb_i,
    input  logic           wb_we_i,
    input  logic [31:0]    wb_adr_i,
    input  logic [31:0]    wb_dat_i,
    input  logic [3:0]     wb_sel_i,
    output logic [31:0]    wb_dat_o,
    output logic           wb_ack_o,
    output logic [NCH-1:0] pwm_o
);
    localparam int unsigned CNT_W = EXP_MAX + DUTY_W;

    logic [NCH-1:0][DUTY_W-1:0] thr_w;
    logic [NCH-1:0][EXP_W-1:0]  exp_w;
    logic [CNT_W-1:0]           cnt_w;

    pwm_bank_regs #(
        .NCH(NCH), .DUTY_W(DUTY_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .BASE(BASE)
    ) u_regs (
        .clk_i(clk_i), .rst_i(rst_i),
        .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
        .adr_i(wb_adr_i), .dat_i(wb_dat_i), .sel_i(wb_sel_i),
        .dat_o(wb_dat_o), .ack_o(wb_ack_o),
        .thr_o(thr_w), .exp_o(exp_w)
    );

    pwm_bank_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .cnt_o(cnt_w)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_bank_chan #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .EXP_W(EXP_W)) u_chan (
            .clk_i(clk_i), .rst_i(rst_i), .cnt_i(cnt_w),
            .thr_i(thr_w[i]), .exp_i(exp_w[i]), .pwm_o(pwm_o[i])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int unsigned NCH     = 8,
    parameter int unsigned DUTY_W  = 8,
    parameter int unsigned EXP_W   = 5,
    parameter int unsigned EXP_MAX = 23,
    parameter int unsigned CNT_W   = 31,
    parameter logic [31:0] BASE    = 32'hFEED_0000
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       cyc_i,
    input logic                       stb_i,
    input logic [31:0]                adr_i,
    input logic                       ack_i,
    input logic [NCH-1:0]             pwm_i,
    input logic [NCH-1:0][DUTY_W-1:0] thr_i,
    input logic [NCH-1:0][EXP_W-1:0]  exp_i,
    input logic [CNT_W-1:0]           cnt_i
);
    localparam int unsigned WIN_LSB = $clog2(NCH) + 3;

    logic in_win;
    assign in_win = (adr_i[31:WIN_LSB] == BASE[31:WIN_LSB]);

    AST_RST_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (pwm_i == '0 && cnt_i == '0)); // R1

    AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_i |=> !ack_i); // R2

    AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && !$past(rst_i)) |-> $past(cyc_i && stb_i && in_win)); // R2

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (cnt_i == CNT_W'($past(cnt_i) + 1'b1))); // R8

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(thr_i[i]) == '0) |-> !pwm_i[i]); // R7

        AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
            32'(exp_i[i]) <= EXP_MAX); // R5
    end
endmodule

bind pwm_bank pwm_bank_chk #(
    .NCH(NCH), .DUTY_W(DUTY_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
    .CNT_W(CNT_W), .BASE(BASE)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i),
    .adr_i(wb_adr_i), .ack_i(wb_ack_o), .pwm_i(pwm_o),
    .thr_i(thr_w), .exp_i(exp_w), .cnt_i(cnt_w)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    localparam logic [31:0] BASE = 32'hFEED_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] adr = '0, dat = '0;
    logic [3:0]  sel = '0;
    logic [31:0] rdat;
    logic        ack;
    logic [7:0]  pwm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank u_dut (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(dat), .wb_sel_i(sel),
        .wb_dat_o(rdat), .wb_ack_o(ack), .pwm_o(pwm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ra(input int ofs);
        return BASE + 32'(ofs * 4);
    endfunction

    task automatic bus(input logic [31:0] a, input logic w, input logic [31:0] d,
                       input logic [3:0] s, output logic acked, output logic [31:0] rd);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d; sel = s;
        acked = 1'b0; rd = '0;
        for (int k = 0; k < 8 && !acked; k++) begin
            @(negedge clk);
            if (ack) begin acked = 1'b1; rd = rdat; end
        end
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input int ofs, input logic [31:0] d);
        logic a; logic [31:0] r;
        bus(ra(ofs), 1'b1, d, 4'hF, a, r);
        chk("R2 write ack", 32'(a), 32'd1);
    endtask

    task automatic rd_chk(input string req, input int ofs, input logic [31:0] exp);
        logic a; logic [31:0] r;
        bus(ra(ofs), 1'b0, '0, 4'hF, a, r);
        chk("R2 read ack", 32'(a), 32'd1);
        chk(req, r, exp);
    endtask

    task automatic t_reset();
        chk("R1 outputs low after reset", 32'(pwm), 32'd0);
        for (int i = 0; i < 16; i++) rd_chk("R1 register zero after reset", i, 32'd0);
    endtask

    task automatic t_regs();
        wr(2, 32'hABCD_125A);
        rd_chk("R3 R4 threshold low byte zero-extended", 2, 32'h5A);
        wr(9, 32'd5);
        rd_chk("R4 exponent readback", 9, 32'd5);
        wr(10, 32'd31);
        rd_chk("R5 exponent 31 clamps to 23", 10, 32'd23);
        wr(11, 32'd24);
        rd_chk("R5 exponent 24 clamps to 23", 11, 32'd23);
        wr(12, 32'h27);
        rd_chk("R5 only low five bits kept", 12, 32'd7);
        wr(13, 32'd23);
        rd_chk("R5 exponent 23 kept", 13, 32'd23);
    endtask

    task automatic t_sel();
        logic a; logic [31:0] r;
        bus(ra(2), 1'b1, 32'h0000_0077, 4'b1110, a, r);
        rd_chk("R3 write without lane 0 ignored", 2, 32'h5A);
    endtask

    task automatic t_window();
        logic a; logic [31:0] r;
        bus(BASE + 32'h40, 1'b1, 32'h33, 4'hF, a, r);
        chk("R2 address above window not acked", 32'(a), 32'd0);
        bus(BASE - 32'h40 + 32'h8, 1'b1, 32'h33, 4'hF, a, r);
        chk("R2 address below window not acked", 32'(a), 32'd0);
        rd_chk("R2 outside write left register alone", 2, 32'h5A);
    endtask

    task automatic t_duty();
        int cnt [8];
        for (int i = 0; i < 8; i++) begin wr(i, 32'd0); wr(8 + i, 32'd0); end
        wr(0, 32'd1); wr(1, 32'd128); wr(2, 32'd255); wr(3, 32'd0);
        wr(4, 32'd64); wr(12, 32'd1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            for (int i = 0; i < 8; i++) cnt[i] += int'(pwm[i]);
        end
        chk("R6 v=1 n=0 high count", 32'(cnt[0]), 32'd510);
        chk("R6 v=128 n=0 high count", 32'(cnt[1]), 32'd256);
        chk("R6 v=255 n=0 high count", 32'(cnt[2]), 32'd2);
        chk("R7 v=0 stays low", 32'(cnt[3]), 32'd0);
        chk("R6 v=64 n=1 high count", 32'(cnt[4]), 32'd384);
        chk("R7 untouched channel low", 32'(cnt[7]), 32'd0);
    endtask

    task automatic t_align();
        int falls [3];
        int bad = 0;
        logic [7:0] prev;
        wr(0, 32'd1); wr(1, 32'd1); wr(2, 32'd1);
        wr(8, 32'd0); wr(9, 32'd1); wr(10, 32'd2);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) falls[i] = 0;
        prev = pwm;
        for (int k = 0; k < 2048; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++)
                if (prev[i] && !pwm[i]) falls[i]++;
            if (prev[1] && !pwm[1] && !(prev[0] && !pwm[0])) bad++;
            if (prev[2] && !pwm[2] && !(prev[1] && !pwm[1])) bad++;
            prev = pwm;
        end
        chk("R8 n=0 falls in 2048 cycles", 32'(falls[0]), 32'd8);
        chk("R8 n=1 falls in 2048 cycles", 32'(falls[1]), 32'd4);
        chk("R8 n=2 falls in 2048 cycles", 32'(falls[2]), 32'd2);
        chk("R8 slower falls coincide with faster", 32'(bad), 32'd0);
    endtask

    task automatic t_update();
        wr(5, 32'd1); wr(13, 32'd0);
        repeat (300) @(negedge clk);
        wr(5, 32'd0);
        @(negedge clk);
        chk("R9 zero threshold visible one cycle after ack", 32'(pwm[5]), 32'd0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sel();
        t_window();
        t_duty();
        t_align();
        t_update();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule